// File: doc/BRIEF.md
# Scalar Double-Precision Predicate Comparator

This block compares the low 64-bit IEEE-754 double-precision lane of a first source against a 64-bit second operand. The comparison is selected by a 5-bit predicate code. Each code combines a relation (equal, less, less-or-equal, their negations, greater forms, ordered, unordered, constant false or true) with two attributes. The first is whether a NaN operand makes the comparison true or false. The second is whether a quiet NaN counts as an invalid operation.

The outcome can be placed in one of three ways, chosen per request by a placement input:
- **Two-operand form:** a 128-bit vector whose upper lane keeps the present destination value.
- **Three-operand form:** a 128-bit vector whose upper lane is copied from the first source.
- **Mask form:** a single mask bit, gated by a write-mask bit, with zeroing.

Two status flags come out with every result: invalid operation and denormal operand. The block has one registered stage. A request is accepted on a cycle with `in_valid` high, and its result appears with a one-cycle `out_valid` strobe on the next cycle.

Top module: `fp_scalar_cmp`

## Requirements
- R1: A value is a NaN when its 11-bit exponent (bits 62:52) is all ones and its 52-bit fraction is nonzero. The pair is unordered when either operand is a NaN. In that case every ordered relation (equal, less, greater) is false, and the unordered relation is true.
- R2: Predicate codes 0 to 15 evaluate these relations, in order: EQ, LT, LE, UNORD, NOT-EQ, NOT-LT, NOT-LE, ORD, EQ-or-unordered, NOT-GE, NOT-GT, FALSE, EQ-and-ordered-negated (NE ordered), GE, GT, TRUE. All negated forms are true on unordered input, except code 12, which is false on unordered input.
- R3: Code 16+k evaluates the same relation as code k, for k = 0 to 15.
- R4: With `place_mode` = 0, only predicate bits 2:0 are used. Result bits 63:0 are all ones when true and all zeros when false. Bits 127:64 equal `dst_hi`. `res_mask` is zero.
- R5: With `place_mode` = 1 or 3, all 5 predicate bits are used. Bits 63:0 carry the all-ones or all-zeros mask, and bits 127:64 equal `src1[127:64]`. `res_mask` is zero.
- R6: With `place_mode` = 2, `res_mask[0]` is the comparison result when `wm_bit` = 1 or `wm_en` = 0, and 0 otherwise. `res_mask` bits above 0 are zero, and `res_vec` is zero.
- R7: `flag_inv` is set when either operand is a signaling NaN (fraction bit 51 clear). It is also set when either operand is a quiet NaN and the predicate is signaling. A predicate is signaling when (bit0 XOR bit1 XOR bit4) of the effective code is 1.
- R8: `flag_den` is set when either operand is subnormal, meaning a zero exponent with a nonzero fraction.
- R9: +0 and -0 compare equal. Ordering follows sign and magnitude, and the magnitude order is reversed when both operands are negative. Infinities order beyond all finite values.
- R10: Results and flags are registered one cycle after an `in_valid` cycle, and `out_valid` is high for exactly that cycle. Without `in_valid`, the outputs hold their values.
- R11: While reset is asserted and after it is released, all outputs are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| place_mode | input | 2 | Result placement: 0 two-operand, 1/3 three-operand, 2 mask |
| pred | input | 5 | Comparison predicate code |
| wm_en | input | 1 | Write-masking enabled (mask form) |
| wm_bit | input | 1 | Write-mask bit 0 (mask form) |
| src1 | input | 128 | First source; low lane is the left-hand operand |
| src2_lo | input | 64 | Second operand (right-hand) |
| dst_hi | input | 64 | Present upper lane of the destination (two-operand form) |
| out_valid | output | 1 | Result strobe |
| res_vec | output | 128 | Vector-form result |
| res_mask | output | 8 | Mask-form result |
| flag_inv | output | 1 | Invalid-operation status |
| flag_den | output | 1 | Denormal-operand status |

## Verification
Some properties are checked on every cycle:
- The strobe timing and the hold of the outputs between requests.
- The all-ones or all-zeros shape of the low lane.
- The zero upper mask bits and the zeroing of a write-masked mask bit.
- The copy of the first source's upper lane.
- Raising the invalid flag on a signaling NaN.
- The absence of any ordered relation on unordered input.

Only the bench's sweep can show that each of the 32 codes gives the right truth value for every operand class, and that the two-operand form ignores predicate bits 4:3. The sweep also covers the signaling attribute on quiet NaNs, the signed-zero and negative-ordering corners, and the denormal flag.

// File: rtl/fp64cmp_pkg.sv
package fp64cmp_pkg;

    typedef enum logic [1:0] {
        PLACE_KEEP = 2'd0,
        PLACE_SRC1 = 2'd1,
        PLACE_MASK = 2'd2,
        PLACE_ALT  = 2'd3
    } place_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_zero;
        logic is_sub;
    } fpcls_t;

endpackage

// File: rtl/fp64_classify.sv
module fp64_classify
    import fp64cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0] val,
    output fpcls_t                cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones, exp_none, frac_any;

    always_comb begin
        exp_f    = val[EXP_W+FRAC_W-1 -: EXP_W];
        frac_f   = val[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_none = ~|exp_f;
        frac_any = |frac_f;
        cls.is_nan  = exp_ones & frac_any;
        cls.is_snan = exp_ones & frac_any & ~frac_f[FRAC_W-1];
        cls.is_zero = exp_none & ~frac_any;
        cls.is_sub  = exp_none & frac_any;
    end
endmodule

// File: rtl/fp64_order.sv
module fp64_order #(
    parameter int LANE_W = 64
) (
    input  logic [LANE_W-1:0] opa,
    input  logic [LANE_W-1:0] opb,
    input  logic              zero_a,
    input  logic              zero_b,
    input  logic              unord,
    output logic              ord_eq,
    output logic              ord_lt
);
    localparam int MAG_W = LANE_W - 1;

    logic [MAG_W-1:0] mag_a, mag_b;
    logic             sgn_a, sgn_b, both_zero, eq_raw, lt_raw;

    always_comb begin
        mag_a     = opa[MAG_W-1:0];
        mag_b     = opb[MAG_W-1:0];
        sgn_a     = opa[LANE_W-1];
        sgn_b     = opb[LANE_W-1];
        both_zero = zero_a & zero_b;
        eq_raw    = both_zero | (opa == opb);
        if (sgn_a != sgn_b)
            lt_raw = sgn_a & ~both_zero;
        else if (!sgn_a)
            lt_raw = mag_a < mag_b;
        else
            lt_raw = mag_a > mag_b;
        ord_eq = ~unord & eq_raw;
        ord_lt = ~unord & lt_raw & ~eq_raw;
    end
endmodule

// File: rtl/fp64_pred_eval.sv
module fp64_pred_eval #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] code,
    input  logic              unord,
    input  logic              ord_eq,
    input  logic              ord_lt,
    output logic              truth,
    output logic              signaling
);
    logic base;

    always_comb begin
        unique case (code[1:0])
            2'd0:    base = ord_eq;
            2'd1:    base = ord_lt;
            2'd2:    base = ord_lt | ord_eq;
            default: base = unord & ~code[3];
        endcase
        if (code[3] && code[1:0] != 2'd3)
            base = base | unord;
        truth     = base ^ code[2];
        signaling = code[0] ^ code[1] ^ code[CODE_W-1];
    end
endmodule

// File: rtl/fp_scalar_cmp.sv
module fp_scalar_cmp
    import fp64cmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int CODE_W = 5,
    parameter int MASK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               place_mode,
    input  logic [CODE_W-1:0]        pred,
    input  logic                     wm_en,
    input  logic                     wm_bit,
    input  logic [2*(EXP_W+FRAC_W+1)-1:0] src1,
    input  logic [EXP_W+FRAC_W:0]    src2_lo,
    input  logic [EXP_W+FRAC_W:0]    dst_hi,
    output logic                     out_valid,
    output logic [2*(EXP_W+FRAC_W+1)-1:0] res_vec,
    output logic [MASK_W-1:0]        res_mask,
    output logic                     flag_inv,
    output logic                     flag_den
);
    localparam int LANE_W    = EXP_W + FRAC_W + 1;
    localparam int VEC_W     = 2 * LANE_W;
    localparam int LEGACY_W  = 3;
    localparam int N_OPS     = 2;

    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  vec;
        logic [MASK_W-1:0] mask;
        logic              inv;
        logic              den;
    } stage_t;

    stage_t st_d, st_q;

    place_e            mode_e;
    logic [LANE_W-1:0] lanes [N_OPS];
    fpcls_t            cls   [N_OPS];
    logic [CODE_W-1:0] code_eff;
    logic              unord, ord_eq, ord_lt, truth, signaling;
    logic              snan_any, sub_any;

    assign mode_e   = place_e'(place_mode);
    assign lanes[0] = src1[LANE_W-1:0];
    assign lanes[1] = src2_lo;

    generate
        for (genvar g = 0; g < N_OPS; g++) begin : g_cls
            fp64_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
                .val (lanes[g]),
                .cls (cls[g])
            );
        end
    endgenerate

    assign unord    = cls[0].is_nan  | cls[1].is_nan;
    assign snan_any = cls[0].is_snan | cls[1].is_snan;
    assign sub_any  = cls[0].is_sub  | cls[1].is_sub;
    assign code_eff = (mode_e == PLACE_KEEP)
                    ? {{(CODE_W-LEGACY_W){1'b0}}, pred[LEGACY_W-1:0]} : pred;

    fp64_order #(.LANE_W(LANE_W)) u_ord (
        .opa    (lanes[0]),
        .opb    (lanes[1]),
        .zero_a (cls[0].is_zero),
        .zero_b (cls[1].is_zero),
        .unord  (unord),
        .ord_eq (ord_eq),
        .ord_lt (ord_lt)
    );

    fp64_pred_eval #(.CODE_W(CODE_W)) u_pred (
        .code      (code_eff),
        .unord     (unord),
        .ord_eq    (ord_eq),
        .ord_lt    (ord_lt),
        .truth     (truth),
        .signaling (signaling)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.inv  = snan_any | (unord & signaling);
            st_d.den  = sub_any;
            st_d.mask = '0;
            unique case (mode_e)
                PLACE_KEEP: st_d.vec = {dst_hi, {LANE_W{truth}}};
                PLACE_MASK: begin
                    st_d.vec     = '0;
                    st_d.mask[0] = truth & (wm_bit | ~wm_en);
                end
                default:    st_d.vec = {src1[VEC_W-1:LANE_W], {LANE_W{truth}}};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign res_vec   = st_q.vec;
    assign res_mask  = st_q.mask;
    assign flag_inv  = st_q.inv;
    assign flag_den  = st_q.den;

    AST_NAN_NO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        unord |-> !(ord_eq || ord_lt)); // R1
    AST_LOW_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(place_mode) != PLACE_MASK) |->
        (res_vec[LANE_W-1:0] == '0 || res_vec[LANE_W-1:0] == '1)); // R4
    AST_UPPER_FROM_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (place_mode == PLACE_SRC1 || place_mode == PLACE_ALT)) |=>
        (res_vec[VEC_W-1:LANE_W] == $past(src1[VEC_W-1:LANE_W]))); // R5
    AST_MASK_ZEROING: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && place_mode == PLACE_MASK && wm_en && !wm_bit) |=>
        (res_mask == '0 && res_vec == '0)); // R6
    AST_MASK_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        res_mask[MASK_W-1:1] == '0); // R6
    AST_INV_ON_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan_any) |=> flag_inv); // R7
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_vec) && $stable(res_mask))); // R10
endmodule

// File: tb/sim_fp_scalar_cmp.sv
`timescale 1ns/1ps
module sim_fp_scalar_cmp;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   place_mode = '0;
    logic [4:0]   pred = '0;
    logic         wm_en = 1'b0, wm_bit = 1'b0;
    logic [127:0] src1 = '0;
    logic [63:0]  src2_lo = '0, dst_hi = '0;
    logic         out_valid, flag_inv, flag_den;
    logic [127:0] res_vec;
    logic [7:0]   res_mask;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    fp_scalar_cmp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .place_mode(place_mode),
        .pred(pred), .wm_en(wm_en), .wm_bit(wm_bit), .src1(src1),
        .src2_lo(src2_lo), .dst_hi(dst_hi), .out_valid(out_valid),
        .res_vec(res_vec), .res_mask(res_mask), .flag_inv(flag_inv),
        .flag_den(flag_den)
    );

    function automatic logic [63:0] opval(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000; // +0
            1:  return 64'h8000_0000_0000_0000; // -0
            2:  return 64'h3FF0_0000_0000_0000; // +1
            3:  return 64'hBFF0_0000_0000_0000; // -1
            4:  return 64'h4000_0000_0000_0000; // +2
            5:  return 64'hC000_0000_0000_0000; // -2
            6:  return 64'h7FF0_0000_0000_0000; // +inf
            7:  return 64'hFFF0_0000_0000_0000; // -inf
            8:  return 64'h7FF8_0000_0000_0001; // qnan
            9:  return 64'h7FF0_0000_0000_0001; // snan
            10: return 64'hFFF8_0000_0000_0000; // -qnan
            11: return 64'h0000_0000_0000_0003; // +sub
            12: return 64'h800F_FFFF_FFFF_FFFF; // -sub
            default: return 64'h7FEF_FFFF_FFFF_FFFF; // max
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    function automatic logic [63:0] okey(input logic [63:0] x);
        logic [63:0] y;
        y = (x[62:0] == 0) ? 64'h0 : x;
        return y[63] ? ~y : (y | 64'h8000_0000_0000_0000);
    endfunction

    function automatic bit ref_truth(input logic [63:0] a, b, input logic [4:0] p);
        bit un, eqo, lto, gto;
        un  = is_nan(a) || is_nan(b);
        eqo = !un && okey(a) == okey(b);
        lto = !un && okey(a) <  okey(b);
        gto = !un && okey(a) >  okey(b);
        case (p[3:0])
            0:  return eqo;
            1:  return lto;
            2:  return lto || eqo;
            3:  return un;
            4:  return !eqo;
            5:  return !lto;
            6:  return !(lto || eqo);
            7:  return !un;
            8:  return eqo || un;
            9:  return !(gto || eqo);
            10: return !gto;
            11: return 1'b0;
            12: return !un && !eqo;
            13: return gto || eqo;
            14: return gto;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit ref_inv(input logic [63:0] a, b, input logic [4:0] p);
        bit quiet_code, sig;
        quiet_code = (p[3:0] inside {0, 3, 4, 7, 8, 11, 12, 15});
        sig = (!quiet_code) ^ p[4];
        return (is_nan(a) && !a[51]) || (is_nan(b) && !b[51]) ||
               ((is_nan(a) || is_nan(b)) && sig);
    endfunction

    function automatic bit ref_den(input logic [63:0] a, b);
        return (a[62:52] == 0 && a[51:0] != 0) || (b[62:52] == 0 && b[51:0] != 0);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    logic [127:0] last_vec;
    logic [7:0]   last_mask;

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && res_vec == 0 && res_mask == 0 && !flag_inv && !flag_den,
            "R11", "reset state", {res_vec[126:0], out_valid}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && res_vec == 0, "R11", "after release", res_vec, 128'h0);

        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 32; p++) begin
                for (int i = 0; i < 14; i++) begin
                    for (int j = 0; j < 14; j++) begin
                        logic [63:0] a, b;
                        logic [4:0]  pe;
                        bit t, gate;
                        logic [127:0] ev;
                        logic [7:0]   em;
                        string tag;
                        a = opval(i);
                        b = opval(j);
                        place_mode = 2'(m);
                        pred = 5'(p);
                        wm_en  = ((i + j + p) % 3) != 0;
                        wm_bit = ((i * 3 + j + p) % 2) != 0;
                        src1 = {64'hA5A5_0000_0000_0000 ^ 64'(i * 97 + p), a};
                        src2_lo = b;
                        dst_hi = 64'h5A5A_1234_0000_0000 ^ 64'(j * 31 + m);
                        in_valid = 1'b1;
                        pe = (m == 0) ? {2'b00, pred[2:0]} : pred;
                        t = ref_truth(a, b, pe);
                        gate = wm_bit || !wm_en;
                        em = '0;
                        if (m == 0)      ev = {dst_hi, {64{t}}};
                        else if (m == 2) begin ev = '0; em[0] = t && gate; end
                        else             ev = {src1[127:64], {64{t}}};
                        if (m == 0 && p > 7)                 tag = "R4";
                        else if (m == 2)                     tag = "R6";
                        else if (is_nan(a) || is_nan(b))     tag = "R1";
                        else if (a[62:0] == 0 && b[62:0] == 0) tag = "R9";
                        else if (p >= 16)                    tag = "R3";
                        else                                 tag = "R2";
                        @(negedge clk);
                        chk(out_valid == 1'b1, "R10", "strobe", {127'h0, out_valid}, 128'h1);
                        chk(res_vec[63:0] == ev[63:0], tag, "low lane", res_vec, ev);
                        chk(res_vec[127:64] == ev[127:64], (m == 0) ? "R4" : "R5",
                            "upper lane", res_vec, ev);
                        chk(res_mask == em, "R6", "mask", {120'h0, res_mask}, {120'h0, em});
                        chk(flag_inv == ref_inv(a, b, pe), "R7", "invalid",
                            {127'h0, flag_inv}, {127'h0, ref_inv(a, b, pe)});
                        chk(flag_den == ref_den(a, b), "R8", "denormal",
                            {127'h0, flag_den}, {127'h0, ref_den(a, b)});
                        last_vec = ev;
                        last_mask = em;
                    end
                end
            end
        end

        in_valid = 1'b0;
        place_mode = 2'd1;
        src1 = '1;
        dst_hi = '1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "strobe drops", {127'h0, out_valid}, 128'h0);
        @(negedge clk);
        chk(res_vec == last_vec && res_mask == last_mask, "R10", "hold while idle",
            res_vec, last_vec);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule